// File: doc/BRIEF.md
# Microcontroller Power Mode Sequencer

This block decides which clocks of a small 8-bit microcontroller run. Software writes a two-bit power-control register. Bit 0 requests a light sleep in which only the processor stops. Bit 1 requests a deep sleep in which every clock and the oscillator stop. The block drives enables for the processor clock, the peripheral clock and the oscillator. It also drives a force flag and a forced level for the external address-latch and program-store strobes.

A light sleep ends on any interrupt that is both pending and enabled. A deep sleep ends only through an external interrupt pin that is enabled, configured as level-sensitive and held low. The pin is first passed through a synchronizer. When it is seen low, the oscillator is turned back on and a hold counter measures how long the pin stays low. The processor is released only after the pin has been low for the full restart interval. If the pin returns high before then, the block goes back to full deep sleep.

The states are RUN, IDLE (light sleep), DOWN (deep sleep) and WARM (oscillator restarting). The transitions are:
- RUN to IDLE on a write of 01.
- RUN to DOWN on a write with bit 1 set.
- IDLE to RUN on an enabled pending interrupt.
- DOWN to WARM when a qualified pin is seen low.
- WARM to DOWN when the pin is released early.
- WARM to RUN when the hold count completes.
- Any state to RUN on hardware reset.

Top module: `pmc_top`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, the block is in RUN: cpu_clk_en, per_clk_en and osc_en are all 1, strb_ovr is 0, and mode_idle and mode_pdn are both 0.
- R2: In RUN, a write (ctl_wr=1) with ctl_din=2'b01 enters IDLE at the next edge. In IDLE, cpu_clk_en=0, per_clk_en=1, osc_en=1 and mode_idle=1.
- R3: In RUN, a write with ctl_din=2'b10 enters DOWN at the next edge. In DOWN, cpu_clk_en, per_clk_en and osc_en are all 0 and mode_pdn=1.
- R4: The strobes follow the mode. In IDLE, strb_ovr=1 and strb_val=1. In DOWN and WARM, strb_ovr=1 and strb_val=0. In RUN, strb_ovr=0.
- R5: In IDLE, any bit set in both irq_pend and irq_en makes the block return to RUN. mode_idle clears and cpu_clk_en returns to 1 on that same edge. A pending flag whose enable is 0 has no effect.
- R6: In DOWN, an external pin (ext_n, active low) whose ext_en and ext_lvl bits are both 1 leads to WARM. The pin passes through a 2-stage synchronizer, so osc_en becomes 1 three edges after the pin falls. cpu_clk_en and per_clk_en stay 0 and mode_pdn stays 1.
- R7: If the qualified pin stays low, the block reaches RUN HOLD edges after entering WARM, which is 3+HOLD edges after the pin falls (HOLD defaults to 1024). mode_pdn clears and cpu_clk_en rises on the same edge.
- R8: If the pin goes high in WARM before the count completes, the block returns to DOWN with osc_en=0. The hold count restarts from zero on the next low period.
- R9: In DOWN, the following are ignored as wake sources: internal pending flags, pins with ext_lvl=0 (edge-configured), and pins with ext_en=0. With any of these, osc_en stays 0.
- R10: Writes are ignored outside RUN. In RUN, a write of 2'b00 changes nothing.
- R11: Asserting rst_n low in IDLE or in WARM returns the block at once to the R1 state.
- R12: A write of 2'b11 in RUN enters DOWN, not IDLE, because the deep-sleep bit has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ctl_wr | input | 1 | Write strobe for the power-control register |
| ctl_din | input | 2 | Write data: bit 0 is light sleep, bit 1 is deep sleep |
| irq_pend | input | N_IRQ | Pending flags of all interrupt sources |
| irq_en | input | N_IRQ | Enables of all interrupt sources |
| ext_n | input | N_EXT | Raw external interrupt pins, active low |
| ext_en | input | N_EXT | Enables of the external interrupt pins |
| ext_lvl | input | N_EXT | 1 = pin is level-sensitive, 0 = edge-configured |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| strb_ovr | output | 1 | Strobes are forced to strb_val |
| strb_val | output | 1 | Forced strobe level |
| mode_idle | output | 1 | Light-sleep bit of the control register |
| mode_pdn | output | 1 | Deep-sleep bit of the control register |

## Verification
Two events can fall on the same edge. One is a pin release and the last count step in WARM. The other is a deep-sleep exit, where the mode bit clears on the same edge that the processor clock enable rises. The bench first provokes an early release after a partial count. It then holds the pin for exactly the full interval and samples one edge before and on the release edge. An early release of the processor, or a counter that was not cleared, shows up as cpu_clk_en=1 one edge too soon. A bound property also requires that the processor clock be enabled on the edge where mode_pdn falls.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2,
        PM_WARM = 2'd3
    } pm_state_t;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
    parameter int N_IRQ = 4,
    parameter int N_EXT = 2
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] ext_n_s,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_lvl,
    output logic             idle_wake,
    output logic             down_wake
);
    always_comb begin
        idle_wake = |(irq_pend & irq_en);
        down_wake = |(~ext_n_s & ext_en & ext_lvl);
    end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int HOLD = 1024
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic [1:0] ctl_din,
    input  logic      idle_wake,
    input  logic      down_wake,
    output pm_state_t state
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    pm_state_t        nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = '0;
        unique case (state)
            PM_RUN: begin
                if (ctl_wr && ctl_din[1])      nxt = PM_DOWN;
                else if (ctl_wr && ctl_din[0]) nxt = PM_IDLE;
            end
            PM_IDLE: begin
                if (idle_wake) nxt = PM_RUN;
            end
            PM_DOWN: begin
                if (down_wake) nxt = PM_WARM;
            end
            PM_WARM: begin
                if (!down_wake)       nxt = PM_DOWN;
                else if (cnt == LAST) nxt = PM_RUN;
                else                  cnt_nxt = cnt + 1'b1;
            end
            default: nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PM_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int N_EXT       = 2,
    parameter int HOLD        = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_din,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] ext_n,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_lvl,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             strb_ovr,
    output logic             strb_val,
    output logic             mode_idle,
    output logic             mode_pdn
);
    logic [N_EXT-1:0] ext_n_s;
    logic             idle_wake, down_wake;
    pm_state_t        state;

    pmc_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_n), .q(ext_n_s)
    );

    pmc_wake #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_wake (
        .irq_pend(irq_pend), .irq_en(irq_en), .ext_n_s(ext_n_s),
        .ext_en(ext_en), .ext_lvl(ext_lvl),
        .idle_wake(idle_wake), .down_wake(down_wake)
    );

    pmc_fsm #(.HOLD(HOLD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
        .idle_wake(idle_wake), .down_wake(down_wake), .state(state)
    );

    always_comb begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        osc_en     = 1'b0;
        strb_ovr   = 1'b1;
        strb_val   = 1'b0;
        mode_idle  = 1'b0;
        mode_pdn   = 1'b0;
        unique case (state)
            PM_RUN: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                osc_en     = 1'b1;
                strb_ovr   = 1'b0;
            end
            PM_IDLE: begin
                per_clk_en = 1'b1;
                osc_en     = 1'b1;
                strb_val   = 1'b1;
                mode_idle  = 1'b1;
            end
            PM_DOWN: begin
                mode_pdn   = 1'b1;
            end
            PM_WARM: begin
                osc_en     = 1'b1;
                mode_pdn   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int N_IRQ = 4,
    parameter int HOLD  = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [1:0]       ctl_din,
    input logic [N_IRQ-1:0] irq_pend,
    input logic [N_IRQ-1:0] irq_en,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             strb_ovr,
    input logic             strb_val,
    input logic             mode_idle,
    input logic             mode_pdn
);
    int warm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                warm_cnt <= 0;
        else if (mode_pdn && osc_en) warm_cnt <= warm_cnt + 1;
        else                       warm_cnt <= 0;
    end

    a_r2_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en && ctl_wr && ctl_din == 2'b01 |=> mode_idle && !cpu_clk_en);
    a_r12_down_first: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en && ctl_wr && ctl_din[1] |=> mode_pdn && !mode_idle);
    a_r4_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mode_idle |-> strb_ovr && strb_val);
    a_r4_down_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pdn |-> strb_ovr && !strb_val);
    a_r5_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        mode_idle && |(irq_pend & irq_en) |=> !mode_idle && cpu_clk_en);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode_idle && !(|(irq_pend & irq_en)) |=> mode_idle);
    a_r3_down_gated: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pdn |-> !cpu_clk_en && !per_clk_en);
    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_pdn) |-> cpu_clk_en && warm_cnt >= HOLD);
    a_r1_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_idle && mode_pdn));
endmodule

bind pmc_top pmc_chk #(.N_IRQ(N_IRQ), .HOLD(HOLD)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
    .irq_pend(irq_pend), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .strb_ovr(strb_ovr),
    .strb_val(strb_val), .mode_idle(mode_idle), .mode_pdn(mode_pdn)
);

// File: tb/sim_pmc_top.sv
module sim_pmc_top;
    localparam int HOLD = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_din = 2'b00;
    logic [3:0] irq_pend = '0, irq_en = '0;
    logic [1:0] ext_n = 2'b11, ext_en = 2'b11, ext_lvl = 2'b11;
    logic cpu_clk_en, per_clk_en, osc_en, strb_ovr, strb_val, mode_idle, mode_pdn;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pmc_top #(.N_IRQ(4), .N_EXT(2), .HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
        .irq_pend(irq_pend), .irq_en(irq_en), .ext_n(ext_n), .ext_en(ext_en),
        .ext_lvl(ext_lvl), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .strb_ovr(strb_ovr), .strb_val(strb_val),
        .mode_idle(mode_idle), .mode_pdn(mode_pdn)
    );

    // expected order: cpu, per, osc, ovr, val, idle, pdn
    localparam logic [6:0] E_RUN  = 7'b1110000;
    localparam logic [6:0] E_IDLE = 7'b0111110;
    localparam logic [6:0] E_DOWN = 7'b0001001;
    localparam logic [6:0] E_WARM = 7'b0011001;

    // vector: wr, din[1:0], pend[3:0], en[3:0], expected[6:0]
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 2'b00, 4'b0000, 4'b0000, E_RUN },  // R1 idle bus
        {1'b1, 2'b00, 4'b0000, 4'b0000, E_RUN },  // R10 write 00
        {1'b1, 2'b01, 4'b0000, 4'b0000, E_IDLE},  // R2 R4
        {1'b0, 2'b00, 4'b0001, 4'b0000, E_IDLE},  // R5 not enabled
        {1'b1, 2'b10, 4'b0000, 4'b0000, E_IDLE},  // R10 write in idle
        {1'b0, 2'b00, 4'b0100, 4'b0100, E_RUN },  // R5 wake
        {1'b1, 2'b11, 4'b0000, 4'b0000, E_DOWN},  // R12 R3 R4
        {1'b0, 2'b00, 4'b1111, 4'b1111, E_DOWN},  // R9 internal ignored
        {1'b1, 2'b01, 4'b0000, 4'b0000, E_DOWN}   // R10 write in down
    };

    function automatic logic [6:0] outs();
        return {cpu_clk_en, per_clk_en, osc_en, strb_ovr, strb_val, mode_idle, mode_pdn};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, outs(), exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(2);
        chk("R1 in reset", E_RUN);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset", E_RUN);

        for (int v = 0; v < NV; v++) begin
            ctl_wr   = VEC[v][17];
            ctl_din  = VEC[v][16:15];
            irq_pend = VEC[v][14:11];
            irq_en   = VEC[v][10:7];
            step(1);
            chk($sformatf("R2/R3/R4/R5/R9/R10/R12 vector %0d", v), VEC[v][6:0]);
        end
        ctl_wr = 1'b0; ctl_din = 2'b00; irq_pend = '0; irq_en = '0;

        // R9: edge-configured pin low in DOWN
        ext_lvl = 2'b10; ext_n = 2'b10;
        step(10);
        chk("R9 edge pin ignored", E_DOWN);
        // R9: disabled level pin low
        ext_lvl = 2'b11; ext_en = 2'b10; ext_n = 2'b10;
        step(10);
        chk("R9 disabled pin ignored", E_DOWN);
        ext_en = 2'b11; ext_n = 2'b11;
        step(3);

        // R6 then R8: partial hold then early release
        ext_n = 2'b10;
        step(2);
        chk("R6 synchronizer delay", E_DOWN);
        step(1);
        chk("R6 oscillator on", E_WARM);
        step(17);
        ext_n = 2'b11;
        step(2);
        chk("R8 still warm during sync", E_WARM);
        step(1);
        chk("R8 back to down", E_DOWN);
        step(3);

        // R7: full hold, counter must restart from zero (R8)
        ext_n = 2'b10;
        step(HOLD + 2);
        chk("R7 R8 one edge before release", E_WARM);
        step(1);
        chk("R7 released", E_RUN);
        ext_n = 2'b11;
        step(3);

        // R11: reset in IDLE
        ctl_wr = 1'b1; ctl_din = 2'b01;
        step(1);
        ctl_wr = 1'b0;
        chk("R11 idle entered", E_IDLE);
        #3 rst_n = 1'b0;
        #2 chk("R11 reset from idle", E_RUN);
        step(1);
        rst_n = 1'b1;
        step(1);

        // R11: reset in WARM
        ctl_wr = 1'b1; ctl_din = 2'b10;
        step(1);
        ctl_wr = 1'b0;
        ext_n = 2'b10;
        step(10);
        chk("R11 warm entered", E_WARM);
        #3 rst_n = 1'b0;
        #2 chk("R11 reset from warm", E_RUN);
        ext_n = 2'b11;
        step(1);
        rst_n = 1'b1;
        step(2);
        chk("R1 run after second reset", E_RUN);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule